// File: doc/BRIEF.md
# Per-Processor Interrupt Acceptance Unit

This unit sits beside one processor core and decides which interrupt the core takes next. It takes interrupt messages from two places: the shared routing unit that forwards device interrupts, and the inter-processor message path. Each message carries a vector, a trigger flag and a delivery kind. Fixed-kind messages are held in a pending bitmap with one bit per vector. The unit offers the most urgent pending vector to the core through a request/acknowledge pair, and it records taken vectors in an in-service bitmap until software signals completion.

A pending vector is offered only when its priority class (the upper four bits) is strictly above the processor priority. The processor priority is the higher of the task-priority class and the class of the highest vector in service. System kinds (non-maskable, system-management, external-controller, init and startup) skip the bitmaps and leave as a single-cycle event pulse. Software uses a 32-bit word-addressed register port. Through it software sets the task priority and the spurious-vector/enable register, writes end-of-interrupt, and reads the pending, in-service and trigger bitmaps. When a level-triggered vector is retired, the unit sends a single-cycle end-of-interrupt broadcast back toward the routing side.

Top module: `irq_accept_unit`

## Requirements
- R1: A pending vector is offered (int_req high, int_vec equal to it) only if bits 7:4 of the vector are strictly greater than bits 7:4 of the task-priority register (word address 0x00, bits 7:0). With a priority of 0x00 every pending vector can be offered. With 0xFF none can.
- R2: While a vector is in service, a pending vector is offered only if its class is strictly greater than the class of the highest in-service vector.
- R3: Among eligible pending vectors, the numerically highest one is offered first.
- R4: When the core asserts int_ack while int_req is high, the offered vector's pending bit clears and its in-service bit sets at that same clock edge.
- R5: A write of 0x00000000 to word address 0x02 clears the highest set in-service bit. A write of any other value there changes nothing.
- R6: Accepting a message with msg_level=1 sets the vector's trigger bit, and msg_level=0 clears it. Retiring a vector whose trigger bit is set drives eoi_bcast_valid high for exactly one cycle, one clock after the write, with eoi_bcast_vector equal to that vector. Retiring an edge vector gives no broadcast.
- R7: Message kinds 1 (non-maskable), 2 (system management), 3 (external controller), 4 (init) and 5 (startup) set no pending or in-service bit. Each produces a one-cycle sys_evt_valid pulse one clock later, carrying its kind and vector. Kind 0 is fixed.
- R8: Pending, in-service and trigger bitmaps read as 32-bit words at 0x08+k, 0x10+k and 0x18+k respectively. Word k holds vectors 32k to 32k+31, with bit i of the word for vector 32k+i.
- R9: The spurious register (word address 0x01) resets to 0x000000FF. Its bits 3:0 always read 1, bits 7:4 are writable, and bit 8 is the software enable, which is 0 after reset.
- R10: While the enable bit is 0, messages with msg_from_ipi=0 are ignored. Messages with msg_from_ipi=1 are still accepted.
- R11: Fixed messages with a vector below 0x20 are ignored.
- R12: If int_ack arrives while int_req is low, int_vec shows the spurious vector (spurious register bits 7:0) and no in-service bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Incoming interrupt message strobe |
| msg_vector | input | 8 | Message vector |
| msg_level | input | 1 | 1 = level triggered, 0 = edge |
| msg_kind | input | 3 | Delivery kind (0 fixed, 1..5 system kinds) |
| msg_from_ipi | input | 1 | 1 = inter-processor path, 0 = routing unit |
| int_req | output | 1 | A vector is offered to the core |
| int_vec | output | 8 | Offered vector, or spurious vector when nothing is offered |
| int_ack | input | 1 | Core takes the vector on int_vec |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| sys_evt_valid | output | 1 | System-kind event pulse |
| sys_evt_kind | output | 3 | Kind of the system event |
| sys_evt_vector | output | 8 | Vector of the system event |
| eoi_bcast_valid | output | 1 | End-of-interrupt broadcast for a level vector |
| eoi_bcast_vector | output | 8 | Vector being broadcast |

## Verification
The bench builds the unit with its default parameters: an 8-bit vector space (256 vectors, eight 32-bit bitmap words) and 32 reserved low vectors. With these values, vectors spread over bitmap words 0 to 5 can be set, offered and read back. The class comparison against both the task priority and the in-service level can be driven at both of its extreme settings. The reserved boundary and the spurious fallback also fall at their real positions.

// File: rtl/irq_pkg.sv
// Shared types for the interrupt acceptance unit.
// Assumes message kinds are encoded in three bits; codes 6 and 7 are unused.
package irq_pkg;
    typedef enum logic [2:0] {
        KIND_FIXED   = 3'd0,
        KIND_NMI     = 3'd1,
        KIND_SMI     = 3'd2,
        KIND_EXTCTL  = 3'd3,
        KIND_INIT    = 3'd4,
        KIND_STARTUP = 3'd5
    } msg_kind_e;

    // Register word addresses inside block 0
    localparam int REG_TPR = 0;
    localparam int REG_SVR = 1;
    localparam int REG_EOI = 2;
    // Bitmap blocks, selected by the address bits above the word index
    localparam int BLK_IRR = 1;
    localparam int BLK_ISR = 2;
    localparam int BLK_TMR = 3;

    function automatic logic is_sys_kind(logic [2:0] k);
        return (k >= 3'd1) && (k <= 3'd5);
    endfunction
endpackage

// File: rtl/prio_find.sv
// Highest-set-bit finder over an N-bit map.
// Assumes N is a power of two and IW = log2(N); idx is 0 when no bit is set.
module prio_find #(
    parameter int N  = 256,
    parameter int IW = 8
) (
    input  logic [N-1:0]  bits,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan upward so the last set bit seen (the highest) wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vec_store.sv
// Pending, in-service and trigger bitmaps with one bit per vector.
// Assumes the acknowledged vector and the retired vector differ, which holds
// because an offered vector's class is above every in-service class.
// A new arrival wins over an acknowledge that clears the same pending bit.
module vec_store #(
    parameter int VEC_W = 8,
    localparam int NV   = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_go,
    input  logic [VEC_W-1:0] set_vec,
    input  logic             set_level,
    input  logic             ack_go,
    input  logic [VEC_W-1:0] ack_vec,
    input  logic             eoi_go,
    input  logic [VEC_W-1:0] eoi_vec,
    output logic [NV-1:0]    irr,
    output logic [NV-1:0]    isr,
    output logic [NV-1:0]    tmr
);
    logic [NV-1:0] irr_n, isr_n, tmr_n;

    // Next-state of the three bitmaps from acknowledge, retire and arrival
    always_comb begin
        irr_n = irr;
        isr_n = isr;
        tmr_n = tmr;
        if (ack_go) begin
            irr_n[ack_vec] = 1'b0;
            isr_n[ack_vec] = 1'b1;
        end
        if (eoi_go) begin
            isr_n[eoi_vec] = 1'b0;
        end
        if (set_go) begin
            irr_n[set_vec] = 1'b1;
            tmr_n[set_vec] = set_level;
        end
    end

    // Bitmap registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr <= '0;
            isr <= '0;
            tmr <= '0;
        end else begin
            irr <= irr_n;
            isr <= isr_n;
            tmr <= tmr_n;
        end
    end
endmodule

// File: rtl/reg_port.sv
// Software register port: task priority, spurious/enable, end-of-interrupt
// strobe and bitmap readback. Word addressed, write-only strobe, read is
// combinational. Assumes VEC_W >= 5, so that a bitmap word is 32 vectors.
module reg_port
    import irq_pkg::*;
#(
    parameter int VEC_W  = 8,
    localparam int NV    = 1 << VEC_W,
    localparam int WSEL  = VEC_W - 5,
    localparam int ADDR_W = WSEL + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NV-1:0]     irr,
    input  logic [NV-1:0]     isr,
    input  logic [NV-1:0]     tmr,
    output logic [VEC_W-1:0]  tpr,
    output logic [VEC_W-1:0]  spur_vec,
    output logic              sw_en,
    output logic              eoi_wr
);
    logic [VEC_W-5:0] spur_hi;
    logic [2:0]       blk;
    logic [WSEL-1:0]  word;
    logic [VEC_W-1:0] base;

    assign blk      = bus_addr[ADDR_W-1 -: 3];
    assign word     = bus_addr[WSEL-1:0];
    assign base     = {word, 5'b0};
    assign spur_vec = {spur_hi, 4'hF};
    assign eoi_wr   = bus_we && (blk == 3'd0) && (word == WSEL'(REG_EOI))
                      && (bus_wdata == 32'h0);

    // Writable control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr     <= '0;
            spur_hi <= '1;
            sw_en   <= 1'b0;
        end else if (bus_we && blk == 3'd0) begin
            if (word == WSEL'(REG_TPR)) begin
                tpr <= bus_wdata[VEC_W-1:0];
            end else if (word == WSEL'(REG_SVR)) begin
                spur_hi <= bus_wdata[VEC_W-1:4];
                sw_en   <= bus_wdata[VEC_W];
            end
        end
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = 32'h0;
        case (blk)
            3'd0: begin
                if (word == WSEL'(REG_TPR))      bus_rdata = 32'(tpr);
                else if (word == WSEL'(REG_SVR)) bus_rdata = 32'({sw_en, spur_vec});
            end
            3'(BLK_IRR): bus_rdata = irr[base +: 32];
            3'(BLK_ISR): bus_rdata = isr[base +: 32];
            3'(BLK_TMR): bus_rdata = tmr[base +: 32];
            default:     bus_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/irq_accept_unit.sv
// Per-processor interrupt acceptance unit: filters incoming messages, keeps
// pending/in-service/trigger bitmaps, offers the best eligible vector to the
// core and retires service on an end-of-interrupt write.
// Assumes int_ack is a single-cycle pulse sampled together with int_vec.
module irq_accept_unit
    import irq_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int RSVD_VECS = 32,
    localparam int NV       = 1 << VEC_W,
    localparam int ADDR_W   = VEC_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [VEC_W-1:0]  msg_vector,
    input  logic              msg_level,
    input  logic [2:0]        msg_kind,
    input  logic              msg_from_ipi,
    output logic              int_req,
    output logic [VEC_W-1:0]  int_vec,
    input  logic              int_ack,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sys_evt_valid,
    output logic [2:0]        sys_evt_kind,
    output logic [VEC_W-1:0]  sys_evt_vector,
    output logic              eoi_bcast_valid,
    output logic [VEC_W-1:0]  eoi_bcast_vector
);
    localparam logic [VEC_W-1:0] RSVD_LIM = VEC_W'(RSVD_VECS);

    logic [NV-1:0]    irr_q, isr_q, tmr_q;
    logic [VEC_W-1:0] tpr_q, spur_vec;
    logic             sw_en, eoi_wr;
    logic             irr_any, isr_any;
    logic [VEC_W-1:0] irr_top, isr_top;
    logic [3:0]       ppr_cls;
    logic             src_ok, acc_fixed, acc_sys, ack_go, eoi_go;

    // Source gate: routed messages need the software enable
    assign src_ok    = msg_valid && (msg_from_ipi || sw_en);
    assign acc_fixed = src_ok && (msg_kind == KIND_FIXED) && (msg_vector >= RSVD_LIM);
    assign acc_sys   = src_ok && is_sys_kind(msg_kind);

    prio_find #(.N(NV), .IW(VEC_W)) u_irr_top (
        .bits(irr_q), .any(irr_any), .idx(irr_top));
    prio_find #(.N(NV), .IW(VEC_W)) u_isr_top (
        .bits(isr_q), .any(isr_any), .idx(isr_top));

    // Processor priority class: task class or top in-service class
    always_comb begin
        ppr_cls = tpr_q[VEC_W-1 -: 4];
        if (isr_any && isr_top[VEC_W-1 -: 4] > ppr_cls) begin
            ppr_cls = isr_top[VEC_W-1 -: 4];
        end
    end

    assign int_req = irr_any && (irr_top[VEC_W-1 -: 4] > ppr_cls);
    assign int_vec = int_req ? irr_top : spur_vec;
    assign ack_go  = int_ack && int_req;
    assign eoi_go  = eoi_wr && isr_any;

    vec_store #(.VEC_W(VEC_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .set_go(acc_fixed), .set_vec(msg_vector), .set_level(msg_level),
        .ack_go(ack_go), .ack_vec(irr_top),
        .eoi_go(eoi_go), .eoi_vec(isr_top),
        .irr(irr_q), .isr(isr_q), .tmr(tmr_q));

    reg_port #(.VEC_W(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irr(irr_q), .isr(isr_q), .tmr(tmr_q),
        .tpr(tpr_q), .spur_vec(spur_vec), .sw_en(sw_en), .eoi_wr(eoi_wr));

    // System-kind event pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_evt_valid  <= 1'b0;
            sys_evt_kind   <= '0;
            sys_evt_vector <= '0;
        end else begin
            sys_evt_valid <= acc_sys;
            if (acc_sys) begin
                sys_evt_kind   <= msg_kind;
                sys_evt_vector <= msg_vector;
            end
        end
    end

    // End-of-interrupt broadcast for level vectors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_bcast_valid  <= 1'b0;
            eoi_bcast_vector <= '0;
        end else begin
            eoi_bcast_valid <= eoi_go && tmr_q[isr_top];
            if (eoi_go) begin
                eoi_bcast_vector <= isr_top;
            end
        end
    end
endmodule

// File: rtl/irq_accept_chk.sv
// Property checker for irq_accept_unit, attached with bind below.
// Assumes it sees the unit's internal bitmaps and task priority.
module irq_accept_chk #(
    parameter int VEC_W     = 8,
    parameter int RSVD_VECS = 32,
    localparam int NV       = 1 << VEC_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msg_valid,
    input logic [VEC_W-1:0] msg_vector,
    input logic [2:0]       msg_kind,
    input logic             msg_from_ipi,
    input logic             sw_en,
    input logic             int_req,
    input logic [VEC_W-1:0] int_vec,
    input logic             int_ack,
    input logic             eoi_wr,
    input logic [VEC_W-1:0] tpr,
    input logic [NV-1:0]    irr,
    input logic [NV-1:0]    isr,
    input logic             eoi_bcast_valid
);
    AST_ABOVE_TPR: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> int_vec[VEC_W-1 -: 4] > tpr[VEC_W-1 -: 4]);  // R1
    AST_NO_LOW_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> int_vec >= VEC_W'(RSVD_VECS));  // R11
    AST_ACK_TO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_req) |=> isr[$past(int_vec)] && !irr[$past(int_vec)]
            || (msg_valid && $past(msg_valid)));  // R4
    AST_WITHDRAWN: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_req && !eoi_wr) |=> $stable(isr));  // R12
    AST_BCAST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast_valid |=> !eoi_bcast_valid || $past(eoi_wr));  // R6
    AST_REDIR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_from_ipi && !sw_en && !int_ack) |=> $stable(irr));  // R10
    AST_SYS_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind != 3'd0 && !int_ack && !eoi_wr) |=> $stable(isr) && $stable(irr));  // R7
endmodule

bind irq_accept_unit irq_accept_chk #(.VEC_W(VEC_W), .RSVD_VECS(RSVD_VECS)) u_chk (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_vector(msg_vector),
    .msg_kind(msg_kind), .msg_from_ipi(msg_from_ipi), .sw_en(sw_en),
    .int_req(int_req), .int_vec(int_vec), .int_ack(int_ack), .eoi_wr(eoi_wr),
    .tpr(tpr_q), .irr(irr_q), .isr(isr_q), .eoi_bcast_valid(eoi_bcast_valid));

// File: tb/test_irq_accept_unit.sv
module test_irq_accept_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [7:0]  msg_vector = '0;
    logic        msg_level = 1'b0;
    logic [2:0]  msg_kind = '0;
    logic        msg_from_ipi = 1'b0;
    logic        int_req;
    logic [7:0]  int_vec;
    logic        int_ack = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_evt_valid;
    logic [2:0]  sys_evt_kind;
    logic [7:0]  sys_evt_vector;
    logic        eoi_bcast_valid;
    logic [7:0]  eoi_bcast_vector;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    logic [7:0] obs_vec;
    string      obs_tag;
    event       obs_ev;

    always #2.5 clk = ~clk;

    irq_accept_unit i_irq_accept_unit (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] v, input logic lvl, input logic [2:0] k, input logic ipi);
        @(negedge clk);
        msg_valid = 1'b1; msg_vector = v; msg_level = lvl; msg_kind = k; msg_from_ipi = ipi;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Driver side of the scoreboard: the vector the core should receive
    task automatic expect_vec(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        obs_tag = tag;
    endtask

    // Core model: take whatever is on int_vec, then hand it to the monitor
    task automatic take();
        @(negedge clk);
        obs_vec = int_vec;
        int_ack = 1'b1;
        -> obs_ev;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    // Monitor: compare each taken vector with the queue head
    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) chk({obs_tag, " unexpected take"}, 32'(obs_vec), 32'hFFFF);
            else chk({obs_tag, " delivered vector"}, 32'(obs_vec), 32'(exp_q.pop_front()));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset values
        rd(6'h01, d); chk("R9 spurious reset", d, 32'h0FF);
        rd(6'h00, d); chk("R1 task priority reset", d, 32'h0);
        chk("R1 no request after reset", 32'(int_req), 32'h0);

        // R10 disabled: routed message dropped, inter-processor accepted
        send(8'h50, 1'b0, 3'd0, 1'b0);
        rd(6'h0A, d); chk("R10 routed dropped while disabled", d, 32'h0);
        send(8'h60, 1'b0, 3'd0, 1'b1);
        rd(6'h0B, d); chk("R8 R10 ipi pending word3", d, 32'h1);
        expect_vec(8'h60, "R10"); take();
        rd(6'h13, d); chk("R4 in-service word3", d, 32'h1);
        rd(6'h0B, d); chk("R4 pending cleared", d, 32'h0);
        wr(6'h02, 32'h0);
        chk("R6 no broadcast for edge", 32'(eoi_bcast_valid), 32'h0);
        rd(6'h13, d); chk("R5 retired", d, 32'h0);

        // R9 enable and hardwired low bits
        wr(6'h01, 32'h13A);
        rd(6'h01, d); chk("R9 spurious write readback", d, 32'h13F);

        // R11 reserved vectors dropped
        send(8'h10, 1'b0, 3'd0, 1'b0);
        rd(6'h08, d); chk("R11 reserved vector dropped", d, 32'h0);
        send(8'h1F, 1'b0, 3'd0, 1'b1);
        rd(6'h08, d); chk("R11 vector 0x1F dropped", d, 32'h0);

        // R3 R2 ordering with in-service gating
        send(8'h41, 1'b0, 3'd0, 1'b0);
        send(8'h92, 1'b0, 3'd0, 1'b0);
        send(8'h75, 1'b0, 3'd0, 1'b0);
        expect_vec(8'h92, "R3"); take();
        #1 chk("R2 lower class held off", 32'(int_req), 32'h0);
        wr(6'h02, 32'h0);
        #1 chk("R2 offered after retire", 32'(int_vec), 32'h75);
        expect_vec(8'h75, "R3"); take();
        wr(6'h02, 32'h0);
        expect_vec(8'h41, "R3"); take();
        // R5 nonzero end-of-interrupt ignored
        wr(6'h02, 32'h1);
        rd(6'h12, d); chk("R5 nonzero write ignored", d, 32'h2);
        wr(6'h02, 32'h0);
        rd(6'h12, d); chk("R5 zero write retires", d, 32'h0);

        // R1 task priority gate
        wr(6'h00, 32'h50);
        send(8'h55, 1'b0, 3'd0, 1'b0);
        #1 chk("R1 equal class not offered", 32'(int_req), 32'h0);
        send(8'h65, 1'b0, 3'd0, 1'b0);
        #1 chk("R1 higher class offered", 32'(int_vec), 32'h65);
        wr(6'h00, 32'hFF);
        #1 chk("R1 priority 0xFF blocks all", 32'(int_req), 32'h0);
        wr(6'h00, 32'h00);
        expect_vec(8'h65, "R1"); take();
        wr(6'h02, 32'h0);
        expect_vec(8'h55, "R1"); take();
        wr(6'h02, 32'h0);

        // R12 withdrawn before acknowledge
        send(8'h80, 1'b0, 3'd0, 1'b0);
        wr(6'h00, 32'hF0);
        expect_vec(8'h3F, "R12"); take();
        rd(6'h14, d); chk("R12 no in-service bit", d, 32'h0);
        rd(6'h0C, d); chk("R12 still pending", d, 32'h1);
        wr(6'h00, 32'h00);
        expect_vec(8'h80, "R12"); take();
        wr(6'h02, 32'h0);

        // R6 level vector broadcast
        send(8'hA3, 1'b1, 3'd0, 1'b0);
        rd(6'h1D, d); chk("R6 trigger bit set", d, 32'h8);
        expect_vec(8'hA3, "R6"); take();
        wr(6'h02, 32'h0);
        chk("R6 broadcast valid", 32'(eoi_bcast_valid), 32'h1);
        chk("R6 broadcast vector", 32'(eoi_bcast_vector), 32'hA3);
        @(negedge clk);
        chk("R6 broadcast one cycle", 32'(eoi_bcast_valid), 32'h0);

        // R7 system kind bypasses bitmaps
        send(8'h02, 1'b0, 3'd1, 1'b0);
        chk("R7 event pulse", 32'(sys_evt_valid), 32'h1);
        chk("R7 event kind", 32'(sys_evt_kind), 32'h1);
        chk("R7 event vector", 32'(sys_evt_vector), 32'h02);
        chk("R7 no request", 32'(int_req), 32'h0);
        rd(6'h08, d); chk("R7 no pending bit", d, 32'h0);
        chk("R7 pulse ended", 32'(sys_evt_valid), 32'h0);
        send(8'h77, 1'b0, 3'd4, 1'b1);
        chk("R7 init event kind", 32'(sys_evt_kind), 32'h4);
        rd(6'h0B, d); chk("R7 init no pending bit", d, 32'h0);

        repeat (2) @(negedge clk);
        chk("scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule